// File: doc/BRIEF.md
# Reset Qualifier and Boot Strap Capture

This block sits between the board-level reset pin and the processor core. It synchronises the active-low reset pin and accepts a reset only after the pin has stayed low for a minimum number of clock cycles. Shorter dips on the pin are treated as noise. While a reset is in force, the core reset output stays low. When the pin is released, the block captures two strap pins in the same cycle that it lets the core run. The first strap selects where code comes from (on-chip or an external bus). The second selects the width of the external bus.

The captured straps set four outputs: a ROMless flag, the external bus width, and the initial address size for external fetches. The fourth output is the start address for the core. It is taken from a boot vector when the boot vector is forced or when the flash status byte is nonzero. Otherwise it is taken from a 16-bit reset vector, which can only point into the lowest 64K of code space. Once the core runs, the code-source pin changes role and becomes a bus wait input for external transfers.

Software can later change the bus width and the address size through a small register write port. All other captured values hold until the next accepted reset.

Top module: `reset_option_ctl`

## Requirements
- R1: A reset is accepted only when the synchronised pin has been seen low on MIN_LOW_CLKS consecutive clock edges. `core_rst_n` then goes low. A shorter low pulse changes no output.
- R2: After an accepted reset, `core_rst_n` rises on the third rising clock edge after `rst_pin_n` returns high (two synchroniser stages plus the capture edge). While `por_n` is low, `core_rst_n` is low.
- R3: On the release edge, `romless` is loaded with the inverse of `code_wait_pin` (pin high means on-chip code, `romless` = 0).
- R4: On the release edge, `bus_16b` is loaded with `bus_width_pin`. A value of 1 selects a 16-bit bus and 0 selects an 8-bit bus. After `por_n`, `bus_16b` is 1.
- R5: On the release edge, `addr_size` is set to 20 in ROMless mode and to 12 otherwise.
- R6: A write with `cfg_we`=1 and `cfg_sel`=0 loads `cfg_wdata[0]` into `bus_16b` on the next edge, but only when `core_rst_n` is high. A write is ignored while a reset is in force, including on the release edge itself.
- R7: A write with `cfg_sel`=1 loads `addr_size` with `cfg_wdata`, clamped to the range 12 to 20. Writes are ignored during reset, as in R6.
- R8: On the release edge, `boot_sel` = `boot_force` OR (`flash_stat` != 0). `start_addr` is then `boot_vec` when `boot_sel` is 1. Otherwise it is `rst_vec` zero-extended, so bits 19:16 are 0.
- R9: `bus_wait` follows `code_wait_pin` while `core_rst_n` is high and is 0 while it is low.
- R10: Changes on the strap, boot and vector inputs after release have no effect on `romless`, `boot_sel` or `start_addr` until the next accepted reset.
- R11: While `por_n` is low, the outputs take these values: `romless`=0, `bus_16b`=1, `addr_size`=20, `boot_sel`=0, `start_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Synchronous active-low power-on reset for the block's own state |
| rst_pin_n | input | 1 | Raw active-low reset pin, asynchronous |
| code_wait_pin | input | 1 | Code-source strap at release; bus wait input afterwards |
| bus_width_pin | input | 1 | Bus-width strap (1 = 16-bit, 0 = 8-bit) |
| boot_force | input | 1 | Forces use of the boot vector |
| flash_stat | input | STAT_W | Flash status byte; nonzero selects the boot vector |
| rst_vec | input | VEC_W | Reset vector word read from location 0 |
| boot_vec | input | ADDR_W | Boot vector start address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 = bus width, 1 = address size |
| cfg_wdata | input | 5 | Configuration write data |
| core_rst_n | output | 1 | Qualified active-low reset to the core |
| romless | output | 1 | 1 when code is fetched from the external bus |
| bus_16b | output | 1 | External bus width (1 = 16-bit) |
| addr_size | output | 5 | External address size in bits (12 to 20) |
| bus_wait | output | 1 | Bus wait request for external transfers |
| boot_sel | output | 1 | 1 when the start address comes from the boot vector |
| start_addr | output | ADDR_W | Start address handed to the core |

## Verification
A software write to the bus-width or address-size register can fall on the same edge as strap capture. It can also fall on the edge where a reset is accepted. The bench holds `cfg_we` high across a whole reset-and-release sequence, so a write is pending on the acceptance edge, on every edge of the reset, and on the release edge. The cycle-level reference model decides each case from R6 and R7. A write on the acceptance edge lands. Writes during the reset, including on the release edge, are dropped, so the strap value wins. A write on the next edge after release lands. Every output is compared with the model on every cycle.

// File: rtl/rso_pkg.sv
// Shared constants, write-target encoding and the address-size clamp
// for the reset option controller.
package rso_pkg;

    localparam int ASZ_MIN = 12;
    localparam int ASZ_MAX = 20;
    localparam int ASZ_W   = 5;

    // Target of a configuration write.
    typedef enum logic {
        CFG_BUSW = 1'b0,
        CFG_ASZ  = 1'b1
    } cfg_sel_e;

    // Limit a written address size to the supported range.
    function automatic logic [ASZ_W-1:0] clamp_asz(input logic [ASZ_W-1:0] v);
        if (v < ASZ_W'(ASZ_MIN))
            return ASZ_W'(ASZ_MIN);
        else if (v > ASZ_W'(ASZ_MAX))
            return ASZ_W'(ASZ_MAX);
        else
            return v;
    endfunction

endpackage

// File: rtl/rso_rst_qual.sv
// Reset qualifier.
// Synchronises the raw reset pin and holds in_reset high once the pin has
// been seen low for MIN_LOW_CLKS consecutive edges. It clears in_reset on
// the first edge where the synchronised pin reads high again, and flags
// that edge with release_p.
// Assumes: MIN_LOW_CLKS >= 1 and SYNC_STAGES >= 1. por_n is synchronous
// and holds the core in reset.
module rso_rst_qual #(
    parameter int MIN_LOW_CLKS = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic in_reset,
    output logic release_p
);
    localparam int CNT_W = $clog2(MIN_LOW_CLKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_seen;
    logic [CNT_W-1:0]       low_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage capture of the pin.
            always_ff @(posedge clk) begin
                if (!por_n) sync_q <= '0;
                else        sync_q <= pin_n;
            end
        end else begin : g_chain
            // Shift the pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!por_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign pin_seen = sync_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturating at the qualifying length.
    always_ff @(posedge clk) begin
        if (!por_n)
            low_cnt <= '0;
        else if (pin_seen)
            low_cnt <= '0;
        else if (low_cnt != CNT_W'(MIN_LOW_CLKS))
            low_cnt <= low_cnt + CNT_W'(1);
    end

    // Enter reset after a qualified low; leave on the first high sample.
    always_ff @(posedge clk) begin
        if (!por_n)
            in_reset <= 1'b1;
        else if (!pin_seen && low_cnt == CNT_W'(MIN_LOW_CLKS - 1))
            in_reset <= 1'b1;
        else if (in_reset && pin_seen)
            in_reset <= 1'b0;
    end

    assign release_p = in_reset & pin_seen;

    // R1
    qual_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(in_reset) |-> low_cnt == CNT_W'(MIN_LOW_CLKS));

    // R1
    glitch_ign_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!in_reset && pin_seen) |=> !in_reset);

    // R2
    release_chk: assert property (@(posedge clk) disable iff (!por_n)
        release_p |=> !in_reset);

endmodule

// File: rtl/rso_boot_sel.sv
// Boot selector and code-source latch.
// On the release pulse it latches the ROMless flag from the code-source
// pin and picks the start address: the boot vector when forced or when
// the flash status is nonzero, otherwise the zero-extended reset vector.
// The values hold until the next release.
// Assumes: VEC_W < ADDR_W. Inputs are stable at the release edge.
module rso_boot_sel #(
    parameter int STAT_W = 8,
    parameter int ADDR_W = 20,
    parameter int VEC_W  = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cap,
    input  logic              code_pin,
    input  logic              boot_force,
    input  logic [STAT_W-1:0] flash_stat,
    input  logic [VEC_W-1:0]  rst_vec,
    input  logic [ADDR_W-1:0] boot_vec,
    output logic              romless,
    output logic              boot_sel,
    output logic [ADDR_W-1:0] start_addr
);
    logic use_boot;

    assign use_boot = boot_force | (|flash_stat);

    // Latch code source and start-address choice at release.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            romless    <= 1'b0;
            boot_sel   <= 1'b0;
            start_addr <= '0;
        end else if (cap) begin
            romless    <= ~code_pin;
            boot_sel   <= use_boot;
            start_addr <= use_boot ? boot_vec : {{(ADDR_W-VEC_W){1'b0}}, rst_vec};
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !cap |=> ($stable(romless) && $stable(boot_sel) && $stable(start_addr)));

    // R8
    page0_chk: assert property (@(posedge clk) disable iff (!por_n)
        !boot_sel |-> start_addr[ADDR_W-1:VEC_W] == '0);

    // R8
    force_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cap && boot_force) |=> boot_sel);

endmodule

// File: rtl/rso_bus_cfg.sv
// External bus configuration.
// Holds the bus width and the address size. Both are loaded from the
// straps on the release pulse. Afterwards software may rewrite either one
// while the core is out of reset. A written address size is clamped.
// Assumes: cap is only high while in_reset is high.
module rso_bus_cfg
    import rso_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             in_reset,
    input  logic             cap,
    input  logic             code_pin,
    input  logic             bw_pin,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [ASZ_W-1:0] cfg_wdata,
    output logic             bus_16b,
    output logic [ASZ_W-1:0] addr_size
);
    cfg_sel_e sel;
    logic     wr_ok;

    assign sel   = cfg_sel_e'(cfg_sel);
    assign wr_ok = cfg_we & ~in_reset;

    // Bus width: strap at release, software write afterwards.
    always_ff @(posedge clk) begin
        if (!por_n)
            bus_16b <= 1'b1;
        else if (cap)
            bus_16b <= bw_pin;
        else if (wr_ok && sel == CFG_BUSW)
            bus_16b <= cfg_wdata[0];
    end

    // Address size: full width for external code, minimum otherwise.
    always_ff @(posedge clk) begin
        if (!por_n)
            addr_size <= ASZ_W'(ASZ_MAX);
        else if (cap)
            addr_size <= code_pin ? ASZ_W'(ASZ_MIN) : ASZ_W'(ASZ_MAX);
        else if (wr_ok && sel == CFG_ASZ)
            addr_size <= clamp_asz(cfg_wdata);
    end

    // R7
    asz_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        (addr_size >= ASZ_W'(ASZ_MIN)) && (addr_size <= ASZ_W'(ASZ_MAX)));

    // R6
    busw_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
        (in_reset && !cap) |=> $stable(bus_16b));

endmodule

// File: rtl/reset_option_ctl.sv
// Reset option controller (top).
// Qualifies the reset pin, captures the code-source and bus-width straps
// at release, selects the core start address, and turns the code-source
// pin into a bus wait input once the core runs.
// Assumes: strap pins are held until the third clock edge after the reset
// pin rises.
module reset_option_ctl
    import rso_pkg::*;
#(
    parameter int MIN_LOW_CLKS = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int STAT_W       = 8,
    parameter int ADDR_W       = 20,
    parameter int VEC_W        = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              code_wait_pin,
    input  logic              bus_width_pin,
    input  logic              boot_force,
    input  logic [STAT_W-1:0] flash_stat,
    input  logic [VEC_W-1:0]  rst_vec,
    input  logic [ADDR_W-1:0] boot_vec,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ASZ_W-1:0]  cfg_wdata,
    output logic              core_rst_n,
    output logic              romless,
    output logic              bus_16b,
    output logic [ASZ_W-1:0]  addr_size,
    output logic              bus_wait,
    output logic              boot_sel,
    output logic [ADDR_W-1:0] start_addr
);
    logic in_reset;
    logic release_p;

    rso_rst_qual #(
        .MIN_LOW_CLKS (MIN_LOW_CLKS),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_qual (
        .clk       (clk),
        .por_n     (por_n),
        .pin_n     (rst_pin_n),
        .in_reset  (in_reset),
        .release_p (release_p)
    );

    rso_boot_sel #(
        .STAT_W (STAT_W),
        .ADDR_W (ADDR_W),
        .VEC_W  (VEC_W)
    ) u_boot (
        .clk        (clk),
        .por_n      (por_n),
        .cap        (release_p),
        .code_pin   (code_wait_pin),
        .boot_force (boot_force),
        .flash_stat (flash_stat),
        .rst_vec    (rst_vec),
        .boot_vec   (boot_vec),
        .romless    (romless),
        .boot_sel   (boot_sel),
        .start_addr (start_addr)
    );

    rso_bus_cfg u_bus (
        .clk       (clk),
        .por_n     (por_n),
        .in_reset  (in_reset),
        .cap       (release_p),
        .code_pin  (code_wait_pin),
        .bw_pin    (bus_width_pin),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .bus_16b   (bus_16b),
        .addr_size (addr_size)
    );

    // Core reset follows the qualifier; the pin becomes a wait input in run.
    assign core_rst_n = ~in_reset;
    assign bus_wait   = ~in_reset & code_wait_pin;

    // R9
    wait_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n |-> !bus_wait);

endmodule

// File: tb/tb_reset_option_ctl.sv
module tb_reset_option_ctl;
    localparam int MINL = 8;

    logic        clk = 1'b0;
    logic        por_n, rst_pin_n, code_wait_pin, bus_width_pin, boot_force;
    logic [7:0]  flash_stat;
    logic [15:0] rst_vec;
    logic [19:0] boot_vec;
    logic        cfg_we, cfg_sel;
    logic [4:0]  cfg_wdata;
    logic        core_rst_n, romless, bus_16b, bus_wait, boot_sel;
    logic [4:0]  addr_size;
    logic [19:0] start_addr;

    int n_chk = 0;
    int n_fail = 0;

    reset_option_ctl #(.MIN_LOW_CLKS(MINL)) dut (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
        .code_wait_pin(code_wait_pin), .bus_width_pin(bus_width_pin),
        .boot_force(boot_force), .flash_stat(flash_stat), .rst_vec(rst_vec),
        .boot_vec(boot_vec), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .core_rst_n(core_rst_n), .romless(romless),
        .bus_16b(bus_16b), .addr_size(addr_size), .bus_wait(bus_wait),
        .boot_sel(boot_sel), .start_addr(start_addr)
    );

    always #5 clk = ~clk;

    // Behavioural reference model state
    bit  hist[$];
    int  m_low;
    bit  m_inrst, m_romless, m_bus16, m_boot;
    int  m_asz;
    int  m_start;

    function automatic int clampv(input int v);
        if (v < 12) return 12;
        if (v > 20) return 20;
        return v;
    endfunction

    always @(posedge clk) begin
        bit seen;
        bit old_inrst;
        if (!por_n) begin
            hist = {1'b0, 1'b0};
            m_low = 0; m_inrst = 1; m_romless = 0; m_bus16 = 1;
            m_asz = 20; m_boot = 0; m_start = 0;
        end else begin
            seen = hist[0];
            old_inrst = m_inrst;
            if (old_inrst && seen) begin
                m_inrst   = 0;
                m_romless = !code_wait_pin;
                m_bus16   = bus_width_pin;
                m_asz     = code_wait_pin ? 12 : 20;
                m_boot    = boot_force || (flash_stat != 0);
                m_start   = m_boot ? int'(boot_vec) : int'(rst_vec);
            end else if (!old_inrst && cfg_we) begin
                if (!cfg_sel) m_bus16 = cfg_wdata[0];
                else          m_asz   = clampv(int'(cfg_wdata));
            end
            if (!seen && m_low == MINL - 1) m_inrst = 1;
            if (seen) m_low = 0;
            else if (m_low < MINL) m_low++;
            void'(hist.pop_front());
            hist.push_back(rst_pin_n);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    bit cmp_on = 0;
    // Compare every output with the model on every cycle, away from the edge.
    always @(negedge clk) if (cmp_on) begin
        chk(core_rst_n === !m_inrst, "R1/R2 core_rst_n", core_rst_n, !m_inrst);
        chk(romless === m_romless, "R3/R10 romless", romless, m_romless);
        chk(bus_16b === m_bus16, "R4/R6 bus_16b", bus_16b, m_bus16);
        chk(int'(addr_size) == m_asz && !$isunknown(addr_size), "R5/R7 addr_size", addr_size, m_asz);
        chk(boot_sel === m_boot, "R8/R10 boot_sel", boot_sel, m_boot);
        chk(int'(start_addr) == m_start && !$isunknown(start_addr), "R8/R10 start_addr", start_addr, m_start);
        chk(bus_wait === (!m_inrst && code_wait_pin), "R9 bus_wait", bus_wait, !m_inrst && code_wait_pin);
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        por_n = 0; rst_pin_n = 1; code_wait_pin = 1; bus_width_pin = 1;
        boot_force = 0; flash_stat = 8'h00; rst_vec = 16'h1234; boot_vec = 20'hABCDE;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 5'd0;
        cmp_on = 1;
        cyc(3);
        // R11: power-on state
        chk(core_rst_n == 0 && romless == 0 && bus_16b == 1, "R11 por state", {core_rst_n, romless, bus_16b}, 3'b001);
        chk(addr_size == 20 && start_addr == 0, "R11 por size/addr", addr_size, 20);
        por_n = 1;
        cyc(6);
        // R3 R4 R5 R8: single-chip, 16-bit, reset vector
        chk(core_rst_n == 1 && romless == 0 && bus_16b == 1, "R3/R4 single-chip", {core_rst_n, romless, bus_16b}, 3'b101);
        chk(addr_size == 12, "R5 single-chip size", addr_size, 12);
        chk(boot_sel == 0 && start_addr == 20'h01234, "R8 reset vector", start_addr, 20'h01234);

        // R6 / R7: software writes
        cfg_we = 1; cfg_sel = 0; cfg_wdata = 5'd0; cyc(1);
        cfg_sel = 1; cfg_wdata = 5'd5; cyc(1);
        chk(addr_size == 12 && bus_16b == 0, "R6/R7 write low clamp", addr_size, 12);
        cfg_wdata = 5'd31; cyc(1);
        chk(addr_size == 20, "R7 write high clamp", addr_size, 20);
        cfg_wdata = 5'd16; cyc(1);
        chk(addr_size == 16, "R7 write in range", addr_size, 16);
        cfg_we = 0; cyc(1);

        // R1: short pulse ignored
        rst_pin_n = 0; cyc(MINL - 1); rst_pin_n = 1; cyc(6);
        chk(core_rst_n == 1 && addr_size == 16, "R1 short pulse ignored", core_rst_n, 1);

        // R2 R3 R4 R5 R8: ROMless, 8-bit, boot via status byte
        code_wait_pin = 0; bus_width_pin = 0; flash_stat = 8'h01;
        rst_pin_n = 0; cyc(MINL + 4);
        chk(core_rst_n == 0, "R1 long pulse accepted", core_rst_n, 0);
        rst_pin_n = 1; cyc(2);
        chk(core_rst_n == 0, "R2 not yet released", core_rst_n, 0);
        cyc(1);
        chk(core_rst_n == 1 && romless == 1 && bus_16b == 0 && addr_size == 20, "R2/R3/R5 romless release",
            {core_rst_n, romless, bus_16b}, 3'b110);
        chk(boot_sel == 1 && start_addr == 20'hABCDE, "R8 boot by status", start_addr, 20'hABCDE);

        // R9 / R10: pin role change and no recapture
        code_wait_pin = 1; bus_width_pin = 1; flash_stat = 0; rst_vec = 16'h0F0F; cyc(1);
        chk(bus_wait == 1 && romless == 1 && start_addr == 20'hABCDE, "R9/R10 pin is wait", bus_wait, 1);
        code_wait_pin = 0; cyc(3);
        chk(bus_wait == 0 && bus_16b == 0, "R9/R10 wait low", bus_wait, 0);

        // R6 collision: write held across acceptance, reset, release
        cfg_we = 1; cfg_sel = 0; cfg_wdata = 5'd1;
        code_wait_pin = 1; bus_width_pin = 0; boot_force = 1;
        rst_pin_n = 0; cyc(MINL + 3); rst_pin_n = 1; cyc(3);
        chk(core_rst_n == 1 && bus_16b == 0, "R6 capture beats write", bus_16b, 0);
        cyc(1);
        chk(bus_16b == 1, "R6 write after release", bus_16b, 1);
        chk(boot_sel == 1 && start_addr == 20'hABCDE, "R8 forced boot", start_addr, 20'hABCDE);
        cfg_we = 0;

        // R8: no force, zero status uses reset vector
        boot_force = 0; rst_pin_n = 0; cyc(MINL + 2); rst_pin_n = 1; cyc(5);
        chk(boot_sel == 0 && start_addr == 20'h00F0F, "R8 back to reset vector", start_addr, 20'h00F0F);

        // R11: por again mid-run
        por_n = 0; cyc(2);
        chk(core_rst_n == 0 && bus_16b == 1 && addr_size == 20, "R11 por mid-run", addr_size, 20);
        por_n = 1; cyc(6);
        cmp_on = 0;
        finish_run();
    end
endmodule